// File: doc/BRIEF.md
# Prioritized Core Interrupt Event Controller

This block sits beside a processor's program sequencer and decides which interrupt event runs next. Each request line feeds an edge detector. A rising edge sets a bit in a latch register, and that bit stays set however briefly the line was high. Software sets a mask register that enables each level. The lowest-numbered level that is both latched and enabled is offered to the sequencer through a dispatch handshake. The offer carries the level number and the handler address held in an internal vector table.

When the sequencer accepts the offer, three things happen on the same clock edge. The chosen latch bit is cleared, the matching in-service bit is set, and in-service bit 4 is raised. Bit 4 is a global "no further events" flag, so level 4 is reserved and never carries a request. The flag drops only when the sequencer reports that the return address has been saved. A return-from-interrupt strobe clears the highest-priority in-service bit, so nested handlers unwind in order. A new event can preempt a running handler only if its level is strictly higher in priority than every level already in service.

Top module: `evc_core_event_ctrl`

## Requirements
- R1: A rising edge on a request line sets its latch bit on that clock edge. The bit stays set after the line falls. A line held high latches only once, so a latch bit cleared while the line stays high does not set again.
- R2: A latched level whose mask bit is 0 raises no dispatch and stays latched. Reading the latch register shows it.
- R3: `disp_valid_o` is high only for a level that is both latched and masked-in. Among such levels, `disp_id_o` names the lowest-numbered one.
- R4: `disp_vec_o` equals the vector-table entry of `disp_id_o`. The register port writes and reads entry `reg_idx_i` with select code 3.
- R5: On an accepted dispatch (`disp_valid_o` and `disp_ready_i` high at the same clock edge), the chosen latch bit clears and the matching in-service bit sets at that edge.
- R6: An accepted dispatch also sets in-service bit 4. While bit 4 is set, `disp_valid_o` stays low.
- R7: `ra_saved_i` clears in-service bit 4. `rti_i` leaves bit 4 unchanged.
- R8: When in-service bit 4 is clear, a level is dispatched only if its index is lower than the lowest in-service index other than 4.
- R9: `rti_i` clears the lowest-indexed in-service bit, not counting bit 4.
- R10: Select code 0 writes the mask. `disp_valid_o` rises in the cycle after the write edge when it enables a latched level. Select code 1 writes ones to clear latch bits. Select code 2 reads the in-service register, and a write to it has no effect.
- R11: Request line 4 is reserved: its edges never latch and it is never dispatched.
- R12: After reset, the mask, latch, in-service and vector registers read 0 and no dispatch is offered. A line that is already high when reset is released is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_EV | Raw request lines, one per level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 latch, 2 in-service, 3 vector |
| reg_idx_i | input | IDX_W | Vector-table entry index |
| reg_wdata_i | input | VEC_W | Write data |
| reg_rdata_o | output | VEC_W | Read data for the selected register (combinational) |
| disp_valid_o | output | 1 | Dispatch offered |
| disp_id_o | output | IDX_W | Level being offered |
| disp_vec_o | output | VEC_W | Handler address for the offered level |
| disp_ready_i | input | 1 | Sequencer accepts the offer |
| ra_saved_i | input | 1 | Return address has been saved |
| rti_i | input | 1 | Return from interrupt |

## Verification
The hardest situation to reach from the ports is two levels in service at once while a third level waits. In that state the global-disable bit, the preemption rule and the unwinding order all interact. The bench sweeps every ordered pair of non-reserved levels. For each pair it latches both levels while they are masked, enables them with one write, and services them. In between it strobes the return-address-saved signal, which shows that the lower-priority level stays blocked until the return strobe. A dedicated sequence then nests a high-priority handler inside a low-priority one, while a level below both stays latched, and unwinds the two in order.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_INSRV = 2'd2,
    SEL_VECT  = 2'd3
  } evc_sel_e;

  // index of the lowest set bit among the first n bits, n when none is set
  function automatic int lowest_set(input logic [31:0] v, input int n);
    int r;
    r = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/evc_req_latch.sv
module evc_req_latch #(
  parameter int NUM_EV  = 16,
  parameter int RSV_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] req_i,
  input  logic [NUM_EV-1:0] clr_i,
  output logic [NUM_EV-1:0] latch_o,
  output logic [NUM_EV-1:0] edge_o
);
  localparam logic [NUM_EV-1:0] RSV_MASK = NUM_EV'(1) << RSV_BIT;

  logic [NUM_EV-1:0] prev_q;
  logic [NUM_EV-1:0] latch_q;

  assign edge_o  = req_i & ~prev_q & ~RSV_MASK;
  assign latch_o = latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      latch_q <= '0;
    end else begin
      prev_q  <= req_i;
      latch_q <= (latch_q & ~clr_i) | edge_o;
    end
  end

  a_r1_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_o) |=> ((latch_q & $past(edge_o)) == $past(edge_o)));

  a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q[RSV_BIT]);
endmodule

// File: rtl/evc_vec_table.sv
module evc_vec_table #(
  parameter int NUM_EV = 16,
  parameter int VEC_W  = 32,
  parameter int IDX_W  = $clog2(NUM_EV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VEC_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] disp_idx_i,
  output logic [VEC_W-1:0] disp_vec_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [VEC_W-1:0] rd_vec_o
);
  logic [VEC_W-1:0] tbl_q [NUM_EV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EV; i++) tbl_q[i] <= '0;
    end else if (wr_i) begin
      tbl_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign disp_vec_o = tbl_q[disp_idx_i];
  assign rd_vec_o   = tbl_q[rd_idx_i];
endmodule

// File: rtl/evc_arbiter.sv
module evc_arbiter
  import evc_pkg::*;
#(
  parameter int NUM_EV  = 16,
  parameter int RSV_BIT = 4,
  parameter int IDX_W   = $clog2(NUM_EV)
) (
  input  logic [NUM_EV-1:0] latch_i,
  input  logic [NUM_EV-1:0] mask_i,
  input  logic [NUM_EV-1:0] insrv_i,
  output logic              valid_o,
  output logic [IDX_W:0]    sel_idx_o,
  output logic [IDX_W:0]    top_idx_o
);
  localparam logic [NUM_EV-1:0] RSV_MASK = NUM_EV'(1) << RSV_BIT;

  logic [NUM_EV-1:0] eligible;
  logic [NUM_EV-1:0] running;
  logic              gdis;

  assign eligible  = latch_i & mask_i & ~RSV_MASK;
  assign running   = insrv_i & ~RSV_MASK;
  assign gdis      = insrv_i[RSV_BIT];
  assign sel_idx_o = (IDX_W+1)'(lowest_set(32'(eligible), NUM_EV));
  assign top_idx_o = (IDX_W+1)'(lowest_set(32'(running), NUM_EV));
  assign valid_o   = (|eligible) && !gdis && (sel_idx_o < top_idx_o);
endmodule

// File: rtl/evc_core_event_ctrl.sv
module evc_core_event_ctrl
  import evc_pkg::*;
#(
  parameter int NUM_EV  = 16,
  parameter int VEC_W   = 32,
  parameter int RSV_BIT = 4,
  parameter int IDX_W   = $clog2(NUM_EV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] req_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [VEC_W-1:0]  reg_wdata_i,
  output logic [VEC_W-1:0]  reg_rdata_o,
  output logic              disp_valid_o,
  output logic [IDX_W-1:0]  disp_id_o,
  output logic [VEC_W-1:0]  disp_vec_o,
  input  logic              disp_ready_i,
  input  logic              ra_saved_i,
  input  logic              rti_i
);
  localparam logic [NUM_EV-1:0] RSV_MASK = NUM_EV'(1) << RSV_BIT;
  localparam logic [IDX_W:0]    NONE_IDX = (IDX_W+1)'(NUM_EV);

  evc_sel_e          sel;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] insrv_q;
  logic [NUM_EV-1:0] latch_w;
  logic [NUM_EV-1:0] edge_w;
  logic [NUM_EV-1:0] latch_clr;
  logic [NUM_EV-1:0] entry_set;
  logic [NUM_EV-1:0] rti_clr;
  logic [IDX_W:0]    sel_idx;
  logic [IDX_W:0]    top_idx;
  logic [VEC_W-1:0]  rd_vec;
  logic              accept;
  logic              wr_latch;

  assign sel      = evc_sel_e'(reg_sel_i);
  assign accept   = disp_valid_o && disp_ready_i;
  assign wr_latch = reg_wr_i && (sel == SEL_LATCH);
  assign disp_id_o = sel_idx[IDX_W-1:0];

  assign entry_set = accept ? ((NUM_EV'(1) << sel_idx) | RSV_MASK) : '0;
  assign rti_clr   = (rti_i && top_idx != NONE_IDX) ? (NUM_EV'(1) << top_idx) : '0;
  assign latch_clr = (wr_latch ? reg_wdata_i[NUM_EV-1:0] : '0)
                   | (accept ? (NUM_EV'(1) << sel_idx) : '0);

  evc_req_latch #(.NUM_EV(NUM_EV), .RSV_BIT(RSV_BIT)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(latch_clr),
    .latch_o(latch_w), .edge_o(edge_w)
  );

  evc_arbiter #(.NUM_EV(NUM_EV), .RSV_BIT(RSV_BIT), .IDX_W(IDX_W)) u_arb (
    .latch_i(latch_w), .mask_i(mask_q), .insrv_i(insrv_q),
    .valid_o(disp_valid_o), .sel_idx_o(sel_idx), .top_idx_o(top_idx)
  );

  evc_vec_table #(.NUM_EV(NUM_EV), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_vt (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i && sel == SEL_VECT), .wr_idx_i(reg_idx_i), .wr_data_i(reg_wdata_i),
    .disp_idx_i(disp_id_o), .disp_vec_o(disp_vec_o),
    .rd_idx_i(reg_idx_i), .rd_vec_o(rd_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      insrv_q <= '0;
    end else begin
      if (reg_wr_i && sel == SEL_MASK) mask_q <= reg_wdata_i[NUM_EV-1:0];
      insrv_q <= (insrv_q & ~rti_clr & ~(ra_saved_i ? RSV_MASK : '0)) | entry_set;
    end
  end

  always_comb begin
    case (sel)
      SEL_MASK:  reg_rdata_o = VEC_W'(mask_q);
      SEL_LATCH: reg_rdata_o = VEC_W'(latch_w);
      SEL_INSRV: reg_rdata_o = VEC_W'(insrv_q);
      default:   reg_rdata_o = rd_vec;
    endcase
  end

  a_r3_offer_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> (latch_w[disp_id_o] && mask_q[disp_id_o]));

  a_r6_gdis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    insrv_q[RSV_BIT] |-> !disp_valid_o);

  a_r5_entry_marks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (insrv_q[$past(disp_id_o)] && insrv_q[RSV_BIT]));

  a_r7_ra_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_saved_i && !accept) |=> !insrv_q[RSV_BIT]);

  a_r8_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> (sel_idx < top_idx));

  a_r9_rti_unwinds: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && !accept && top_idx != NONE_IDX) |=> !insrv_q[$past(top_idx[IDX_W-1:0])]);
endmodule

// File: tb/test_evc_core_event_ctrl.sv
module test_evc_core_event_ctrl;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        disp_valid;
  logic [3:0]  disp_id;
  logic [31:0] disp_vec;
  logic        disp_ready = 1'b0;
  logic        ra_saved = 1'b0;
  logic        rti = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  evc_core_event_ctrl i_evc_core_event_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .disp_valid_o(disp_valid), .disp_id_o(disp_id), .disp_vec_o(disp_vec),
    .disp_ready_i(disp_ready), .ra_saved_i(ra_saved), .rti_i(rti)
  );

  function automatic logic [31:0] vexp(input int i);
    return 32'h8000_0000 + 32'(i) * 32'h0000_1234;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input int idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_idx = 4'(idx); reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input int idx, output logic [31:0] v);
    reg_sel = s; reg_idx = 4'(idx);
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse(input int i);
    req[i] = 1'b1; tick(); req[i] = 1'b0;
  endtask

  task automatic take();
    disp_ready = 1'b1; tick(); disp_ready = 1'b0;
  endtask

  task automatic ra();
    ra_saved = 1'b1; tick(); ra_saved = 1'b0;
  endtask

  task automatic ret();
    rti = 1'b1; tick(); rti = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R12: reset state, line high across reset release
    req[3] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(); tick();
    rd(2'd1, 0, v); chk("R12 latch after reset", v, 32'h0);
    rd(2'd0, 0, v); chk("R12 mask after reset", v, 32'h0);
    rd(2'd2, 0, v); chk("R12 insrv after reset", v, 32'h0);
    rd(2'd3, 6, v); chk("R12 vector after reset", v, 32'h0);
    chk("R12 no offer", 32'(disp_valid), 32'h0);
    req[3] = 1'b0; tick();

    // R4: vector table write and readback
    for (int i = 0; i < N; i++) wr(2'd3, i, vexp(i));
    for (int i = 0; i < N; i++) begin
      rd(2'd3, i, v); chk("R4 vector readback", v, vexp(i));
    end

    // R1: held level latches once; W1C clear while high stays clear (R10)
    req[7] = 1'b1; tick(); tick();
    rd(2'd1, 0, v); chk("R1 level latched", v, 32'h80);
    wr(2'd1, 0, 32'h80); tick();
    rd(2'd1, 0, v); chk("R1 no relatch while high", v, 32'h0);
    req[7] = 1'b0; tick();

    // R11: reserved line ignored
    pulse(4);
    rd(2'd1, 0, v); chk("R11 line 4 not latched", v, 32'h0);
    wr(2'd0, 0, 32'hFFFF);
    chk("R11 no offer", 32'(disp_valid), 32'h0);
    wr(2'd0, 0, 32'h0);

    // R10: latch cleared by software is not dispatched after unmask
    pulse(9);
    wr(2'd1, 0, 32'h200);
    wr(2'd0, 0, 32'h200);
    chk("R10 cleared latch not offered", 32'(disp_valid), 32'h0);
    wr(2'd0, 0, 32'h0);
    wr(2'd2, 0, 32'hFFFF);
    rd(2'd2, 0, v); chk("R10 insrv write ignored", v, 32'h0);

    // sweep of all ordered level pairs
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        int lo, hi;
        if (a == b || a == 4 || b == 4) continue;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        pulse(a); pulse(b);
        chk("R2 masked no offer", 32'(disp_valid), 32'h0);
        rd(2'd1, 0, v); chk("R2 both pending", v, (32'h1 << a) | (32'h1 << b));
        wr(2'd0, 0, (32'h1 << a) | (32'h1 << b));
        chk("R10 offer after mask write", 32'(disp_valid), 32'h1);
        chk("R3 lowest index wins", 32'(disp_id), 32'(lo));
        chk("R4 vector of offer", disp_vec, vexp(lo));
        take();
        rd(2'd2, 0, v); chk("R5 R6 insrv on entry", v, (32'h1 << lo) | 32'h10);
        rd(2'd1, 0, v); chk("R5 latch cleared", v, 32'h1 << hi);
        chk("R6 gdis blocks", 32'(disp_valid), 32'h0);
        ra();
        chk("R8 lower level waits", 32'(disp_valid), 32'h0);
        ret();
        rd(2'd2, 0, v); chk("R9 rti clears", v, 32'h0);
        chk("R3 second offer", 32'(disp_valid), 32'h1);
        chk("R3 second id", 32'(disp_id), 32'(hi));
        take(); ra(); ret();
        rd(2'd2, 0, v); chk("R9 all returned", v, 32'h0);
        rd(2'd1, 0, v); chk("R5 latch empty", v, 32'h0);
        wr(2'd0, 0, 32'h0);
      end
    end

    // R7, R8, R9: nesting and global disable
    wr(2'd0, 0, 32'hFFFF);
    pulse(10);
    take();
    ret();
    rd(2'd2, 0, v); chk("R7 rti keeps gdis", v, 32'h10);
    pulse(2);
    chk("R7 still blocked", 32'(disp_valid), 32'h0);
    ra();
    chk("R7 released after ra", 32'(disp_valid), 32'h1);
    chk("R7 id", 32'(disp_id), 32'd2);
    take(); ra(); ret();
    pulse(10); take(); ra();
    pulse(12);
    chk("R8 lower cannot preempt", 32'(disp_valid), 32'h0);
    pulse(2);
    chk("R8 higher preempts", 32'(disp_valid), 32'h1);
    chk("R8 preempt id", 32'(disp_id), 32'd2);
    take();
    rd(2'd2, 0, v); chk("R8 nested insrv", v, 32'h414);
    ra(); ret();
    rd(2'd2, 0, v); chk("R9 inner unwound first", v, 32'h400);
    chk("R8 12 still waits", 32'(disp_valid), 32'h0);
    ret();
    chk("R9 then 12 offered", 32'(disp_id), 32'd12);
    chk("R9 valid", 32'(disp_valid), 32'h1);
    take(); ra(); ret();
    rd(2'd2, 0, v); chk("R9 final empty", v, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule